// File: doc/BRIEF.md
# Secured Code Store Programming Port

This block is the programming-port side of a one-time-programmable code memory. A programmer drives control pins, a 14-bit address split over an 8-bit low port and a 6-bit high port, and an 8-bit data port. The control pins select one of seven operations:

- write a code byte;
- read a code byte back;
- write a byte of a 64-entry scrambling table;
- set one of three lock bits;
- read a fixed identification byte.

Writes happen only on counted strobes that arrive while the high-voltage flag is up.

The block holds the code bytes, the scrambling table and the lock bits. Code read-back is scrambled through the table. The lock bits form a ladder of restrictions. Each restriction is also exported as a flag for the fetch and reset logic of the rest of the chip. A separate erase command returns every stored bit to its blank state.

Top module: `eprom_secure_port`

## Requirements
- R1: An operation is decoded only while `hold_rst`=1 and `fetch_n`=0. The `mode_sel` codes are:
  - 01111: write code.
  - 00111: read code. Needs `prog_n`=1 and `vpp_hi`=0.
  - 01101: write table.
  - 11111: set lock 1.
  - 11100: set lock 2.
  - 10110: set lock 3.
  - 00000: read identification. Needs `prog_n`=1 and `vpp_hi`=0.

  Any other combination is idle, with `data_oe`=0 and `data_out`=0.
- R2: A code read drives `data_oe`=1 and `data_out` = NOT(code XOR table[addr[5:0]]). With a blank table (all ones) the code byte appears unchanged. Code storage holds 2^STORE_AW bytes (default 2048), and the address aliases modulo that depth.
- R3: A code write takes effect on the 5th falling edge of `prog_n` seen while `vpp_hi`=1, with operation, address and data unchanged since the first edge. A change of any of them restarts the count. Edges with `vpp_hi`=0 are not counted.
- R4: Table writes and lock-bit sets take effect on the 25th accepted edge. Fewer edges leave them unchanged.
- R5: Every write ANDs the data port into the stored byte, so a bit can only go from 1 to 0.
- R6: Once lock 1 is set, code and table writes have no effect, and `table_fetch_block` and `ea_latch_req` are 1.
- R7: Once locks 1 and 2 are set, code reads keep `data_oe`=0. Identification reads still work.
- R8: `ext_exec_block` is 1 only when all three locks are set. A restriction applies only when every lower lock is also set, so lock 2 alone restricts nothing.
- R9: Identification reads return 89h at address 30h, 58h at 31h, 54h at 60h, and FFh elsewhere.
- R10: A one-cycle `erase` sets every code byte and table byte to FFh and clears all three locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the strobe logic |
| erase | input | 1 | Blank the whole store |
| hold_rst | input | 1 | Device reset pin level, must be 1 for any operation |
| fetch_n | input | 1 | Program-store strobe pin level, must be 0 for any operation |
| prog_n | input | 1 | Active-low programming strobe |
| vpp_hi | input | 1 | Programming supply at high voltage |
| mode_sel | input | 5 | Operation select pins |
| addr_lo | input | 8 | Address bits 7..0 |
| addr_hi | input | 6 | Address bits 13..8 |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Read data |
| data_oe | output | 1 | Read data port is driven |
| table_fetch_block | output | 1 | Internal code reads from external code are blocked |
| ea_latch_req | output | 1 | External-access pin is latched at reset |
| ext_exec_block | output | 1 | External execution is disabled |

## Verification
The assertions assume the following about the inputs:
- Address, data and `mode_sel` change only while `prog_n` is high.
- `prog_n` stays at each level for at least one clock.
- `erase` is not raised in the same cycle as a strobe.

The bench holds every level for two clocks and moves through an unlisted idle code before each new setup. Strobes are issued only inside that settled window.

// File: rtl/eprom_sec_pkg.sv
package eprom_sec_pkg;
  parameter int DATA_W = 8;

  typedef enum logic [2:0] {
    M_IDLE, M_PGM_CODE, M_VFY_CODE, M_PGM_TBL,
    M_PGM_LB1, M_PGM_LB2, M_PGM_LB3, M_SIG
  } pmode_e;

  function automatic logic [DATA_W-1:0] scramble(input logic [DATA_W-1:0] code,
                                                 input logic [DATA_W-1:0] key);
    return ~(code ^ key);
  endfunction

  function automatic logic [DATA_W-1:0] ident_byte(input logic [15:0] a);
    case (a)
      16'h0030: return 8'h89;
      16'h0031: return 8'h58;
      16'h0060: return 8'h54;
      default:  return 8'hFF;
    endcase
  endfunction

  function automatic logic is_write_mode(input pmode_e m);
    return (m == M_PGM_CODE) || (m == M_PGM_TBL) ||
           (m == M_PGM_LB1) || (m == M_PGM_LB2) || (m == M_PGM_LB3);
  endfunction
endpackage

// File: rtl/eprom_mode_decode.sv
module eprom_mode_decode
  import eprom_sec_pkg::*;
(
  input  logic       hold_rst,
  input  logic       fetch_n,
  input  logic       prog_n,
  input  logic       vpp_hi,
  input  logic [4:0] mode_sel,
  output pmode_e     mode
);
  logic read_ok;
  assign read_ok = prog_n && !vpp_hi;

  always_comb begin
    mode = M_IDLE;
    if (hold_rst && !fetch_n) begin
      case (mode_sel)
        5'b01111: mode = M_PGM_CODE;
        5'b00111: mode = read_ok ? M_VFY_CODE : M_IDLE;
        5'b01101: mode = M_PGM_TBL;
        5'b11111: mode = M_PGM_LB1;
        5'b11100: mode = M_PGM_LB2;
        5'b10110: mode = M_PGM_LB3;
        5'b00000: mode = read_ok ? M_SIG : M_IDLE;
        default:  mode = M_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eprom_pulse_ctr.sv
module eprom_pulse_ctr
  import eprom_sec_pkg::*;
#(
  parameter int KEY_W  = 22,
  parameter int CODE_N = 5,
  parameter int AUX_N  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pmode_e           mode,
  input  logic             prog_n,
  input  logic             vpp_hi,
  input  logic             allow,
  input  logic [KEY_W-1:0] key,
  output logic             commit,
  output logic             pulse_ok
);
  localparam int CNT_W = $clog2(AUX_N + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             prog_q;
  logic [KEY_W-1:0] key_q;
  pmode_e           mode_q;
  logic [CNT_W-1:0] cnt_q, base, bumped, need;
  logic             same, fall;

  assign fall     = prog_q && !prog_n;
  assign pulse_ok = fall && vpp_hi && is_write_mode(mode) && allow;
  assign same     = (key == key_q) && (mode == mode_q);
  assign base     = same ? cnt_q : '0;
  assign bumped   = (base == CNT_MAX) ? base : base + 1'b1;
  assign need     = (mode == M_PGM_CODE) ? CNT_W'(CODE_N) : CNT_W'(AUX_N);
  assign commit   = pulse_ok && (bumped >= need);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q <= 1'b1;
      key_q  <= '0;
      mode_q <= M_IDLE;
      cnt_q  <= '0;
    end else begin
      prog_q <= prog_n;
      key_q  <= key;
      mode_q <= mode;
      cnt_q  <= pulse_ok ? bumped : base;
    end
  end

  // R3: a write only ever lands on an accepted strobe at high voltage
  p_commit_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!prog_n && vpp_hi && prog_q));
  // R3: a changed setup restarts the count from at most one strobe
  p_count_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!same && !pulse_ok) |=> (cnt_q == '0));
endmodule

// File: rtl/eprom_store.sv
module eprom_store
  import eprom_sec_pkg::*;
#(
  parameter int STORE_AW = 11,
  parameter int TBL_AW   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                erase,
  input  logic                wr_code,
  input  logic                wr_tbl,
  input  logic [2:0]          wr_lock,
  input  logic [STORE_AW-1:0] addr,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   code_q,
  output logic [DATA_W-1:0]   tbl_q,
  output logic [2:0]          lock_q
);
  localparam int DEPTH  = 1 << STORE_AW;
  localparam int TDEPTH = 1 << TBL_AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] tbl [TDEPTH];
  logic [TBL_AW-1:0] tidx;

  assign tidx   = addr[TBL_AW-1:0];
  assign code_q = mem[addr];
  assign tbl_q  = tbl[tidx];

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_code) begin
      mem[addr] <= mem[addr] & din;
    end
  end

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < TDEPTH; i++) tbl[i] <= '1;
    end else if (wr_tbl) begin
      tbl[tidx] <= tbl[tidx] & din;
    end
  end

  always_ff @(posedge clk) begin
    if (erase) lock_q <= '0;
    else       lock_q <= lock_q | wr_lock;
  end

  // R6: the write logic never targets the code array past lock 1
  p_no_code_write_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_code |-> !lock_q[0]);
  // R6: the write logic never targets the table past lock 1
  p_no_tbl_write_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tbl |-> !lock_q[0]);
  // R10: lock bits only clear through erase
  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !erase |=> ((lock_q & $past(lock_q)) == $past(lock_q)));
  // R5: a code write never sets a bit
  p_and_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_code && !erase) |=> ((mem[$past(addr)] & ~$past(code_q)) == '0));
endmodule

// File: rtl/eprom_secure_port.sv
module eprom_secure_port
  import eprom_sec_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int LO_W     = 8,
  parameter int STORE_AW = 11,
  parameter int TBL_AW   = 6,
  parameter int CODE_N   = 5,
  parameter int AUX_N    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              hold_rst,
  input  logic              fetch_n,
  input  logic              prog_n,
  input  logic              vpp_hi,
  input  logic [4:0]        mode_sel,
  input  logic [LO_W-1:0]   addr_lo,
  input  logic [ADDR_W-LO_W-1:0] addr_hi,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              table_fetch_block,
  output logic              ea_latch_req,
  output logic              ext_exec_block
);
  localparam int KEY_W = ADDR_W + DATA_W;

  pmode_e            mode;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] code_q, tbl_q;
  logic [2:0]        lock_q, wr_lock;
  logic              commit, pulse_ok, allow, wr_code, wr_tbl;
  logic              lvl1, lvl2, lvl3, vfy_on, sig_on;

  assign addr = {addr_hi, addr_lo};

  eprom_mode_decode u_dec (
    .hold_rst(hold_rst), .fetch_n(fetch_n), .prog_n(prog_n),
    .vpp_hi(vpp_hi), .mode_sel(mode_sel), .mode(mode)
  );

  assign lvl1  = lock_q[0];
  assign lvl2  = lvl1 && lock_q[1];
  assign lvl3  = lvl2 && lock_q[2];
  assign allow = ((mode == M_PGM_CODE) || (mode == M_PGM_TBL)) ? !lvl1 : 1'b1;

  eprom_pulse_ctr #(.KEY_W(KEY_W), .CODE_N(CODE_N), .AUX_N(AUX_N)) u_ctr (
    .clk(clk), .rst_n(rst_n), .mode(mode), .prog_n(prog_n), .vpp_hi(vpp_hi),
    .allow(allow), .key({addr, data_in}), .commit(commit), .pulse_ok(pulse_ok)
  );

  assign wr_code    = commit && (mode == M_PGM_CODE);
  assign wr_tbl     = commit && (mode == M_PGM_TBL);
  assign wr_lock[0] = commit && (mode == M_PGM_LB1);
  assign wr_lock[1] = commit && (mode == M_PGM_LB2);
  assign wr_lock[2] = commit && (mode == M_PGM_LB3);

  eprom_store #(.STORE_AW(STORE_AW), .TBL_AW(TBL_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .erase(erase), .wr_code(wr_code), .wr_tbl(wr_tbl),
    .wr_lock(wr_lock), .addr(addr[STORE_AW-1:0]), .din(data_in),
    .code_q(code_q), .tbl_q(tbl_q), .lock_q(lock_q)
  );

  assign vfy_on = (mode == M_VFY_CODE) && !lvl2;
  assign sig_on = (mode == M_SIG);
  assign data_oe = vfy_on || sig_on;

  always_comb begin
    data_out = '0;
    if (vfy_on)      data_out = scramble(code_q, tbl_q);
    else if (sig_on) data_out = ident_byte(16'(addr));
  end

  assign table_fetch_block = lvl1;
  assign ea_latch_req      = lvl1;
  assign ext_exec_block    = lvl3;

  // R1: the data port is only driven in a read operation
  p_oe_read_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (prog_n && !vpp_hi && hold_rst && !fetch_n));
  // R7: code read-back stays hidden at the second lock level
  p_verify_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q[0] && lock_q[1] && mode_sel == 5'b00111) |-> !data_oe);
  // R8: external execution block implies both lower restrictions
  p_ladder_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_exec_block |-> (table_fetch_block && ea_latch_req));
  // R3: accepted strobes need a write operation
  p_strobe_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_ok |-> (hold_rst && !fetch_n && vpp_hi));
endmodule

// File: tb/eprom_secure_port_test.sv
module eprom_secure_port_test;
  localparam logic [4:0] S_PC = 5'b01111, S_VF = 5'b00111, S_PT = 5'b01101,
                         S_L1 = 5'b11111, S_L2 = 5'b11100, S_L3 = 5'b10110,
                         S_SG = 5'b00000, S_NO = 5'b10101;

  logic clk = 0, rst_n = 0, erase = 0, hold_rst = 1, fetch_n = 0;
  logic prog_n = 1, vpp_hi = 0;
  logic [4:0] mode_sel = S_NO;
  logic [7:0] addr_lo = 0, data_in = 0;
  logic [5:0] addr_hi = 0;
  logic [7:0] data_out;
  logic data_oe, table_fetch_block, ea_latch_req, ext_exec_block;

  int checks = 0, errors = 0;
  logic [7:0] mem [2048];
  logic [7:0] tbl [64];
  logic [2:0] lk;

  always #5 clk = ~clk;

  eprom_secure_port uut (
    .clk(clk), .rst_n(rst_n), .erase(erase), .hold_rst(hold_rst), .fetch_n(fetch_n),
    .prog_n(prog_n), .vpp_hi(vpp_hi), .mode_sel(mode_sel), .addr_lo(addr_lo),
    .addr_hi(addr_hi), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .table_fetch_block(table_fetch_block), .ea_latch_req(ea_latch_req),
    .ext_exec_block(ext_exec_block)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_addr(logic [13:0] a);
    addr_lo = a[7:0];
    addr_hi = a[13:8];
  endtask

  function automatic logic [7:0] exp_vfy(logic [13:0] a);
    return ~(mem[a[10:0]] ^ tbl[a[5:0]]);
  endfunction

  task automatic model_erase();
    for (int i = 0; i < 2048; i++) mem[i] = 8'hFF;
    for (int i = 0; i < 64; i++) tbl[i] = 8'hFF;
    lk = 3'b000;
  endtask

  task automatic do_erase();
    erase = 1; step(1); erase = 0; step(1);
    model_erase();
  endtask

  task automatic strobes(int n);
    for (int k = 0; k < n; k++) begin
      prog_n = 0; step(2); prog_n = 1; step(2);
    end
  endtask

  task automatic pgm(logic [4:0] sel, logic [13:0] a, logic [7:0] d, int n, logic vpp);
    mode_sel = S_NO; prog_n = 1; vpp_hi = 0; step(2);
    mode_sel = sel; set_addr(a); data_in = d; step(2);
    vpp_hi = vpp; step(1);
    strobes(n);
    vpp_hi = 0; step(1);
    if (vpp) begin
      if (sel == S_PC && n >= 5 && !lk[0]) mem[a[10:0]] &= d;
      if (sel == S_PT && n >= 25 && !lk[0]) tbl[a[5:0]] &= d;
      if (sel == S_L1 && n >= 25) lk[0] = 1;
      if (sel == S_L2 && n >= 25) lk[1] = 1;
      if (sel == S_L3 && n >= 25) lk[2] = 1;
    end
  endtask

  task automatic rd(logic [4:0] sel, logic [13:0] a);
    prog_n = 1; vpp_hi = 0; mode_sel = sel; set_addr(a);
    @(negedge clk);
  endtask

  task automatic check_vfy(string tag, logic [13:0] a);
    rd(S_VF, a);
    if (lk[0] && lk[1]) chk({tag, " oe off"}, data_oe, 0);
    else begin
      chk({tag, " oe"}, data_oe, 1);
      chk({tag, " data"}, data_out, exp_vfy(a));
    end
  endtask

  task automatic check_guards(string tag);
    @(negedge clk);
    chk({tag, " fetch block"}, table_fetch_block, lk[0]);
    chk({tag, " ea latch"}, ea_latch_req, lk[0]);
    chk({tag, " ext exec"}, ext_exec_block, &lk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [13:0] alist [24];
    void'($urandom(32'h5EC0DE));
    model_erase();
    step(3); rst_n = 1; step(1);
    do_erase();

    // R1 / R10: blank state, idle code keeps port off
    rd(S_NO, 14'h0030);
    chk("R1 idle oe", data_oe, 0);
    chk("R1 idle data", data_out, 0);
    check_guards("R10 blank");
    check_vfy("R2 blank code", 14'h1234);

    // R9 identification bytes
    rd(S_SG, 14'h0030); chk("R9 sig 30", data_out, 8'h89);
    rd(S_SG, 14'h0031); chk("R9 sig 31", data_out, 8'h58);
    rd(S_SG, 14'h0060); chk("R9 sig 60", data_out, 8'h54);
    rd(S_SG, 14'h0061); chk("R9 sig other", data_out, 8'hFF);
    // R1: read with high voltage flag is idle
    vpp_hi = 1; @(negedge clk); chk("R1 read at vpp", data_oe, 0); vpp_hi = 0;
    // R1: operation gated by hold_rst
    hold_rst = 0; rd(S_SG, 14'h0030); chk("R1 hold_rst low", data_oe, 0); hold_rst = 1;

    // R3: four strobes do nothing, five commit
    pgm(S_PC, 14'h0100, 8'h3C, 4, 1);
    check_vfy("R3 four strobes", 14'h0100);
    pgm(S_PC, 14'h0100, 8'h3C, 5, 1);
    check_vfy("R3 five strobes", 14'h0100);
    // R3: strobes with low voltage ignored
    pgm(S_PC, 14'h0101, 8'h00, 6, 0);
    check_vfy("R3 low vpp", 14'h0101);
    // R3: data change restarts count (3 + 2 strobes)
    pgm(S_PC, 14'h0102, 8'h11, 3, 1);
    data_in = 8'h22; step(2); vpp_hi = 1; step(1); strobes(2); vpp_hi = 0; step(1);
    check_vfy("R3 restart", 14'h0102);
    // R5: AND into stored byte
    pgm(S_PC, 14'h0103, 8'hF0, 5, 1);
    pgm(S_PC, 14'h0103, 8'h3F, 5, 1);
    check_vfy("R5 and", 14'h0103);
    pgm(S_PC, 14'h0103, 8'hFF, 5, 1);
    check_vfy("R5 no set", 14'h0103);

    // R2: random code writes, alias included
    for (int i = 0; i < 24; i++) begin
      alist[i] = 14'($urandom());
      pgm(S_PC, alist[i], 8'($urandom()), 5, 1);
    end
    for (int i = 0; i < 24; i++) check_vfy("R2 random clear table", alist[i]);

    // R4: table needs 25 strobes
    pgm(S_PT, 14'h0005, 8'h0F, 24, 1);
    check_vfy("R4 table 24", 14'h0105);
    pgm(S_PT, 14'h0005, 8'h0F, 25, 1);
    check_vfy("R4 table 25", 14'h0105);
    for (int i = 0; i < 6; i++) pgm(S_PT, 14'($urandom()), 8'($urandom()), 25, 1);
    for (int i = 0; i < 24; i++) check_vfy("R2 random scrambled", alist[i]);
    check_vfy("R2 alias", 14'h0100 | 14'h0800);

    // R8: lock 2 alone restricts nothing; R4 lock needs 25
    pgm(S_L2, 14'h0, 8'h0, 25, 1);
    check_guards("R8 lock2 only");
    check_vfy("R8 lock2 only verify", 14'h0100);
    pgm(S_L1, 14'h0, 8'h0, 24, 1);
    check_guards("R4 lock1 24");

    // R10: erase clears all
    do_erase();
    check_guards("R10 erase");
    check_vfy("R10 code blank", alist[3]);

    // R6: lock 1
    pgm(S_PC, 14'h0200, 8'hA5, 5, 1);
    pgm(S_L1, 14'h0, 8'h0, 25, 1);
    check_guards("R6 lock1");
    pgm(S_PC, 14'h0200, 8'h00, 5, 1);
    check_vfy("R6 code write blocked", 14'h0200);
    pgm(S_PT, 14'h0000, 8'h00, 25, 1);
    check_vfy("R6 table write blocked", 14'h0200);

    // R7: lock 2 on top of lock 1
    pgm(S_L2, 14'h0, 8'h0, 25, 1);
    check_vfy("R7 verify hidden", 14'h0200);
    rd(S_SG, 14'h0031); chk("R7 sig still", data_out, 8'h58);
    check_guards("R7 guards");

    // R8: all three
    pgm(S_L3, 14'h0, 8'h0, 25, 1);
    check_guards("R8 full lock");

    do_erase();
    check_guards("R10 erase after full");
    check_vfy("R10 verify back", 14'h0200);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule